// File: doc/BRIEF.md
# Packed Decimal Add-and-Correct Unit

This unit adds unsigned packed decimal numbers of eight digits by doing ordinary binary additions and then repairing each digit on its own. Software runs three steps. A bias step adds six to every digit of the first operand. An add step sums the biased word and the second operand, and it records which 4-bit digit positions carried out. A correct step then takes six away from every digit that did not carry. A second form of the correct step puts the bias of six back, so its result can feed the next add at once.

The bias step can also flag operands that are not valid decimal. A digit above nine carries out of its nibble once six is added, and when the trap enable is set this raises a sticky trap flag. The carry out of the top digit during an add is offered as the decimal carry. A following word of a longer number can use it. Each accepted operation produces one registered result, one cycle after its strobe.

Top module: `bcd_addcor_unit`

## Requirements
- R1: A word holds eight 4-bit unsigned decimal digits, with digit 0 in bits 3:0 and digit 7 in bits 31:28.
- R2: Opcode 2'b00 (bias) returns opa plus 32'h66666666, taken modulo 2^32.
- R3: A bias operation with trap_en high sets trap_flag in the same cycle its result appears, if any of the eight nibble positions carries out. With trap_en low, a bias operation never sets trap_flag.
- R4: trap_flag stays set until a cycle with trap_clr high. In that cycle it clears, unless a new trap is raised in the same cycle, in which case the new trap wins.
- R5: Opcode 2'b01 (add) returns opa plus opb, taken modulo 2^32. It stores the carry out of every nibble position of that sum in the digit-carry register, and dec_cout shows the carry out of nibble 7.
- R6: Opcode 2'b10 (correct) subtracts 6, modulo 16, from each nibble of opa whose stored carry is clear. It leaves the other nibbles unchanged, and no borrow passes between nibbles.
- R7: Opcode 2'b11 (intermediate correct) gives the R6 result with 6 added back to each nibble, again with no carry between nibbles.
- R8: For valid digits a and b, the sequence bias(a), then add(that result, b), then correct(that sum) gives the decimal sum of a and b modulo 10^8, and dec_cout gives the decimal carry.
- R9: out_valid is high for exactly the one cycle after each cycle with in_valid high. result does not change in any cycle that follows a cycle with in_valid low.
- R10: The digit-carry register and dec_cout change only on add operations. Bias and correct operations issued between adds see the carries from the last add.
- R11: After reset, out_valid, result, dec_cout, trap_flag and the digit-carry register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously. |
| in_valid | input | 1 | Strobe that starts an operation |
| op | input | 2 | Opcode: 00 bias, 01 add, 10 correct, 11 intermediate correct |
| opa | input | 32 | First operand; the word to be corrected in the correct opcodes |
| opb | input | 32 | Second operand; used only by add |
| trap_en | input | 1 | Allows a bias operation to raise the trap |
| trap_clr | input | 1 | Clears the sticky trap flag |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Registered result word |
| dec_cout | output | 1 | Carry out of the top nibble from the last add |
| trap_flag | output | 1 | Sticky flag for an invalid digit |

## Verification
The bench runs operands of all nines, where every digit carries and the top carry must come out, and all-zero operands, where no digit carries and every digit must be corrected. It also runs random valid digits, checked against a decimal reference that adds one digit at a time. A design that corrected the wrong set of nibbles, or let a borrow pass between nibbles, would fail the correct step on a small uncarried digit: 5 must become F and must not touch its neighbour. A carry register that cleared on bias or correct operations would show up when a correct is issued after an intervening bias. A trap flag that was not sticky, or that ignored trap_en, would fail the trap sequence around the clear.

// File: rtl/bcd_addcor_pkg.sv
package bcd_addcor_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] DIGIT_BIAS = 4'h6;

  typedef enum logic [1:0] {
    OP_BIAS = 2'b00,
    OP_ADD  = 2'b01,
    OP_CORR = 2'b10,
    OP_ICOR = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_nibble_chain.sv
// Binary adder built as a ripple of nibble adders; exposes each nibble carry.
module bcd_nibble_chain
  import bcd_addcor_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int W = DIGITS * NIB_W
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [W-1:0]      sum,
  output logic [DIGITS-1:0] nib_cy
);
  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    logic [NIB_W:0] part;
    assign part = {1'b0, a[g*NIB_W +: NIB_W]} + {1'b0, b[g*NIB_W +: NIB_W]}
                + {{NIB_W{1'b0}}, chain[g]};
    assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
    assign chain[g+1] = part[NIB_W];
    assign nib_cy[g]  = part[NIB_W];
  end
endmodule

// File: rtl/bcd_digit_fix.sv
// Per-nibble correction: -6 on uncarried digits, optional +6 re-bias; no inter-nibble carry.
module bcd_digit_fix
  import bcd_addcor_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int W = DIGITS * NIB_W
) (
  input  logic [W-1:0]      din,
  input  logic [DIGITS-1:0] cy,
  input  logic              rebias,
  output logic [W-1:0]      dout
);
  localparam logic [NIB_W-1:0] MINUS_BIAS = NIB_W'(0) - DIGIT_BIAS;

  for (genvar g = 0; g < DIGITS; g++) begin : g_fix
    logic [NIB_W-1:0] adj;
    logic [NIB_W-1:0] rb;
    assign adj = cy[g] ? '0 : MINUS_BIAS;
    assign rb  = rebias ? DIGIT_BIAS : '0;
    assign dout[g*NIB_W +: NIB_W] = din[g*NIB_W +: NIB_W] + adj + rb;
  end
endmodule

// File: rtl/bcd_addcor_unit.sv
module bcd_addcor_unit
  import bcd_addcor_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int W = DIGITS * NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          trap_en,
  input  logic          trap_clr,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          dec_cout,
  output logic          trap_flag
);
  localparam logic [W-1:0] BIAS_WORD = {DIGITS{DIGIT_BIAS}};

  // reset synchronizer: assert async, release on clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  bcd_op_e op_e;
  assign op_e = bcd_op_e'(op);

  logic [W-1:0]      add_b, add_sum, fix_out;
  logic [DIGITS-1:0] add_cy;
  logic [DIGITS-1:0] cy_q, cy_d;
  logic [W-1:0]      res_d;
  logic              trap_d, cout_d;
  logic              res_en, cy_en;

  assign add_b = (op_e == OP_BIAS) ? BIAS_WORD : opb;

  bcd_nibble_chain #(.DIGITS(DIGITS)) u_chain (
    .a(opa), .b(add_b), .sum(add_sum), .nib_cy(add_cy)
  );

  bcd_digit_fix #(.DIGITS(DIGITS)) u_fix (
    .din(opa), .cy(cy_q), .rebias(op_e == OP_ICOR), .dout(fix_out)
  );

  // next-state
  always_comb begin
    res_en = in_valid;
    cy_en  = in_valid && (op_e == OP_ADD);
    unique case (op_e)
      OP_BIAS, OP_ADD: res_d = add_sum;
      default:         res_d = fix_out;
    endcase
    cy_d   = add_cy;
    cout_d = add_cy[DIGITS-1];
    if (in_valid && (op_e == OP_BIAS) && trap_en && (|add_cy)) trap_d = 1'b1;
    else if (trap_clr)                                          trap_d = 1'b0;
    else                                                        trap_d = trap_flag;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cy_q      <= '0;
      dec_cout  <= 1'b0;
      trap_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      trap_flag <= trap_d;
      if (res_en) result <= res_d;
      if (cy_en) begin
        cy_q     <= cy_d;
        dec_cout <= cout_d;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);
  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R4
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (trap_flag && !trap_clr) |=> trap_flag);
  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(in_valid && op == 2'b01) |=> ($stable(cy_q) && $stable(dec_cout)));
  // R3
  trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!trap_flag && !(in_valid && op == 2'b00 && trap_en)) |=> !trap_flag);
endmodule

// File: tb/bcd_addcor_unit_bench.sv
module bcd_addcor_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        trap_en = 1'b0, trap_clr = 1'b0;
  logic        out_valid, dec_cout, trap_flag;
  logic [31:0] result;

  always #2.5 clk = ~clk;  // 200 MHz

  bcd_addcor_unit u_bcd_addcor_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .trap_en(trap_en), .trap_clr(trap_clr), .out_valid(out_valid), .result(result),
    .dec_cout(dec_cout), .trap_flag(trap_flag)
  );

  typedef struct { logic [31:0] res; logic cout; logic trap; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  logic [7:0] m_cy = '0;
  logic       m_trap = 1'b0;
  logic       done = 1'b0;
  localparam logic [31:0] SIX = 32'h66666666;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nib_carries(input logic [31:0] a, input logic [31:0] b);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [32:0] m, p;
      m = (33'd1 << (4*(i+1))) - 33'd1;
      p = ({1'b0, a} & m) + ({1'b0, b} & m);
      c[i] = p[4*(i+1)];
    end
    return c;
  endfunction

  // R1 digit order: digit 0 at bits 3:0
  task automatic dec_ref(input logic [31:0] a, input logic [31:0] b, output logic [31:0] s, output logic co);
    int c = 0;
    s = '0;
    for (int i = 0; i < 8; i++) begin
      int t;
      t = int'(a[4*i +: 4]) + int'(b[4*i +: 4]) + c;
      s[4*i +: 4] = 4'(t % 10);
      c = t / 10;
    end
    co = (c != 0);
  endtask

  function automatic logic [31:0] rand_bcd();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) v[4*i +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  task automatic push(input logic [31:0] r, input string tag);
    item_t it;
    it.res = r; it.cout = m_cy[7]; it.trap = m_trap; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input logic ten);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; trap_en = ten;
  endtask

  task automatic op_bias(input logic [31:0] a, input logic ten);
    drive(2'b00, a, '0, ten);
    if (ten && |nib_carries(a, SIX)) m_trap = 1'b1;
    push(a + SIX, "R2/R3");
  endtask

  task automatic op_add(input logic [31:0] a, input logic [31:0] b);
    drive(2'b01, a, b, 1'b0);
    m_cy = nib_carries(a, b);
    push(a + b, "R5");
  endtask

  task automatic op_fix(input logic [31:0] a, input logic rb, input string tag);
    logic [31:0] r;
    for (int i = 0; i < 8; i++) r[4*i +: 4] = a[4*i +: 4] - (m_cy[i] ? 4'd0 : 4'd6) + (rb ? 4'd6 : 4'd0);
    drive(rb ? 2'b11 : 2'b10, a, '0, 1'b0);
    push(r, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; trap_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // R8 chained decimal add; final item uses the decimal reference
  task automatic chain(input logic [31:0] a, input logic [31:0] b, input logic interm);
    logic [31:0] s; logic co; item_t it;
    dec_ref(a, b, s, co);
    op_bias(a, 1'b1);
    op_add(a + SIX, b);
    drive(interm ? 2'b11 : 2'b10, a + SIX + b, '0, 1'b0);
    it.res = interm ? (s + SIX) : s;  // R7 re-biased digits cannot carry
    it.cout = co; it.trap = m_trap; it.tag = interm ? "R7/R8" : "R8";
    sb.push_back(it);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R9 unexpected out_valid", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(result === it.res, {it.tag, " result"}, result, it.res);
        check(dec_cout === it.cout, {it.tag, " dec_cout R10"}, {31'd0, dec_cout}, {31'd0, it.cout});
        check(trap_flag === it.trap, {it.tag, " trap R3/R4"}, {31'd0, trap_flag}, {31'd0, it.trap});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11
    check(out_valid === 1'b0 && result === '0 && dec_cout === 1'b0 && trap_flag === 1'b0,
          "R11 reset state", result, 32'h0);

    chain(32'h00000000, 32'h00000000, 1'b0);
    chain(32'h99999999, 32'h99999999, 1'b0);
    chain(32'h12345678, 32'h87654321, 1'b0);
    chain(32'h50000000, 32'h50000000, 1'b0);
    chain(32'h00000001, 32'h99999999, 1'b1);
    for (int k = 0; k < 20; k++) chain(rand_bcd(), rand_bcd(), k[0]);
    idle(3);
    check(sb.size() == 0, "R9 all results seen", sb.size(), 0);

    // R6 no borrow between nibbles: all carries clear
    op_add(32'h0, 32'h0);
    op_fix(32'h00000005, 1'b0, "R6 no-borrow");
    // R10 carries survive an intervening bias
    op_add(32'h6666666F, 32'h00000001);
    op_bias(32'h00000000, 1'b0);
    op_fix(32'h00000000, 1'b0, "R10 held carries");
    op_fix(32'h00000000, 1'b1, "R7 held carries");
    idle(3);

    // R3 trap gated by trap_en, then raised
    op_bias(32'h0000000A, 1'b0);
    idle(2);
    check(trap_flag === 1'b0, "R3 trap disabled", {31'd0, trap_flag}, 32'd0);
    op_bias(32'h0000000A, 1'b1);
    op_add(32'h1, 32'h2);           // R4 flag stays set
    idle(2);
    check(trap_flag === 1'b1, "R4 trap sticky", {31'd0, trap_flag}, 32'd1);
    @(negedge clk) trap_clr = 1'b1;
    @(negedge clk) trap_clr = 1'b0;
    m_trap = 1'b0;
    check(trap_flag === 1'b0, "R4 trap cleared", {31'd0, trap_flag}, 32'd0);
    check(out_valid === 1'b0, "R9 no pulse on clear", {31'd0, out_valid}, 32'd0);
    // R4 new trap wins over clear in the same cycle
    @(negedge clk);
    in_valid = 1'b1; op = 2'b00; opa = 32'hB0000000; trap_en = 1'b1; trap_clr = 1'b1;
    m_trap = 1'b1;
    push(32'hB0000000 + SIX, "R4 set beats clear");
    @(negedge clk);
    in_valid = 1'b0; trap_clr = 1'b0; trap_en = 1'b0;
    idle(3);
    check(sb.size() == 0, "R9 queue drained", sb.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule